// File: doc/BRIEF.md
# 1-Wire ROM Command and Search Responder

This block is the transaction layer of a 1-Wire slave whose only content is a 64-bit identity code. It sits on top of a bit-level slot engine. That engine handles all line timing and reports three one-cycle events:
- a reset/presence sequence has finished;
- the master wrote a bit;
- the master opened a read slot.

After each bus reset the responder collects one 8-bit command, least-significant bit first. It then does one of three things:
- It streams its code out as a read-ROM.
- It takes part in the multi-device search.
- It stays silent until the next bus reset.

The 64-bit code comes in on an input, already complete. Bits 7:0 hold the family byte, bits 55:8 hold the serial number and bits 63:56 hold the check byte, and the code is sent from bit 0 upward.

The responder tells the slot engine what to do in each read slot:
- When `tx_en_o` is high, the engine sends `tx_bit_o`.
- When `tx_en_o` is low, the engine leaves the line released, so that slot reads 1.

Several responders share one line, so the master sees the wired-AND of all the slaves that are driving it.

Top module: `owrom_responder`

## Requirements
- R1: After a bus reset strobe, the block collects exactly 8 written bits, least-significant first, as the command. While it collects them, `tx_en_o` stays 0 and read-slot strobes are ignored.
- R2: Command 8'h33 or 8'h0F starts read-ROM. The block then drives `tx_en_o`=1 with `tx_bit_o` = code bit i for i = 0..63, and moves to the next bit on each read-slot strobe.
- R3: After the read slot for code bit 63, the block is silent (`tx_en_o`=0) until the next bus reset.
- R4: Command 8'hF0 starts search. For each code bit i, the first read slot sends bit i and the second read slot sends its complement, both with `tx_en_o`=1.
- R5: In search, after the two read slots for bit i, the next written bit is compared with code bit i. On a match the block moves on to bit i+1. After bit 63 matches, it goes silent until the next bus reset.
- R6: In search, a written bit that differs from the code bit makes the block silent, ignoring all slots until the next bus reset.
- R7: Command 8'h55, 8'hCC or any other unlisted byte produces no bus activity (`tx_en_o`=0) until the next bus reset.
- R8: A bus reset strobe in any state aborts that state and restarts command collection at bit 0.
- R9: With several responders on one line (line = AND over responders of `tx_en_o ? tx_bit_o : 1`), a search in which the master writes 0 whenever both the bit and its complement read 0 isolates exactly one code. The other responders drop out.
- R10: After the synchronous `rst`, the block is silent and ignores written bits and read slots until a bus reset strobe.
- R11: Written-bit strobes during the read phases of read-ROM and search are ignored. Read-slot strobes while search waits for the master's written bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | One-cycle strobe: bus reset and presence completed |
| wr_vld_i | input | 1 | One-cycle strobe: master wrote a bit |
| wr_bit_i | input | 1 | Value of the written bit, valid with `wr_vld_i` |
| rd_req_i | input | 1 | One-cycle strobe: the read slot that used the current `tx_*` value has ended |
| rom_code_i | input | 64 | Identity code; bit 0 is sent first |
| tx_en_o | output | 1 | 1: drive `tx_bit_o` in the next read slot; 0: leave the line released |
| tx_bit_o | output | 1 | Bit to present in the next read slot |

## Verification
The assertions check these rules on every cycle:
- a bus reset always lands in command collection with the bit index at zero;
- the index only holds, steps by one or clears;
- an idle responder stays idle until a bus reset;
- the complement slot inverts the bit just sent;
- a read strobe does not disturb the phase that waits for the master's written bit.

Only the bench scenarios show the following:
- the whole 64-bit stream order;
- which opcodes are accepted and which are refused;
- the drop-out point after a mismatch;
- the way two responders resolve through the wired-AND line during search.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ_A = 8'h33;
    localparam logic [CMD_W-1:0] OP_READ_B = 8'h0F;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_S_TRUE,
        ST_S_CMPL,
        ST_S_WR
    } resp_state_e;

    typedef enum logic [1:0] {
        ACT_SILENT,
        ACT_READ,
        ACT_SEARCH
    } cmd_act_e;

    typedef struct packed {
        logic en;
        logic bit_v;
    } tx_slot_t;

    // Match and skip are recognised but, with a ROM-only slave, lead to silence
    function automatic cmd_act_e decode_cmd(input logic [CMD_W-1:0] op);
        cmd_act_e act;
        case (op)
            OP_READ_A, OP_READ_B: act = ACT_READ;
            OP_SEARCH:            act = ACT_SEARCH;
            OP_MATCH, OP_SKIP:    act = ACT_SILENT;
            default:              act = ACT_SILENT;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_vld,
    input  logic         bit_i,
    output logic         done_o,
    output logic [W-1:0] byte_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          take;

    assign take   = en && bit_vld;
    assign done_o = take && (cnt_q == LAST);
    assign byte_o = {bit_i, sh_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= {bit_i, sh_q[W-1:1]};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owrom_idx.sv
module owrom_idx #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 inc,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 last_o
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
        end else if (inc) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == TOP);
endmodule

// File: rtl/owrom_responder.sv
module owrom_responder
    import owrom_pkg::*;
#(
    parameter int CODE_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_i,
    input  logic              wr_vld_i,
    input  logic              wr_bit_i,
    input  logic              rd_req_i,
    input  logic [CODE_W-1:0] rom_code_i,
    output logic              tx_en_o,
    output logic              tx_bit_o
);
    localparam int IDX_W = $clog2(CODE_W);

    resp_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx;
    logic             idx_last, idx_clr, idx_inc;
    logic             cmd_done;
    logic [CMD_W-1:0] cmd_byte;
    logic             code_bit;
    tx_slot_t         slot;

    owrom_cmd_rx #(.W(CMD_W)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .clr    (bus_rst_i),
        .en     (state_q == ST_CMD),
        .bit_vld(wr_vld_i),
        .bit_i  (wr_bit_i),
        .done_o (cmd_done),
        .byte_o (cmd_byte)
    );

    owrom_idx #(.N(CODE_W)) u_idx (
        .clk   (clk),
        .rst   (rst),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx_o (idx),
        .last_o(idx_last)
    );

    assign code_bit = rom_code_i[idx];

    always_comb begin
        state_d = state_q;
        idx_clr = 1'b0;
        idx_inc = 1'b0;
        if (bus_rst_i) begin
            state_d = ST_CMD;
            idx_clr = 1'b1;
        end else begin
            case (state_q)
                ST_CMD: if (cmd_done) begin
                    case (decode_cmd(cmd_byte))
                        ACT_READ:   state_d = ST_READ;
                        ACT_SEARCH: state_d = ST_S_TRUE;
                        default:    state_d = ST_IDLE;
                    endcase
                end
                ST_READ: if (rd_req_i) begin
                    if (idx_last) state_d = ST_IDLE;
                    else          idx_inc = 1'b1;
                end
                ST_S_TRUE: if (rd_req_i) state_d = ST_S_CMPL;
                ST_S_CMPL: if (rd_req_i) state_d = ST_S_WR;
                ST_S_WR: if (wr_vld_i) begin
                    if (wr_bit_i != code_bit) begin
                        state_d = ST_IDLE;
                    end else if (idx_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_inc = 1'b1;
                        state_d = ST_S_TRUE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        slot = '{en: 1'b0, bit_v: 1'b1};
        case (state_q)
            ST_READ, ST_S_TRUE: slot = '{en: 1'b1, bit_v: code_bit};
            ST_S_CMPL:          slot = '{en: 1'b1, bit_v: ~code_bit};
            default:            slot = '{en: 1'b0, bit_v: 1'b1};
        endcase
    end

    assign tx_en_o  = slot.en;
    assign tx_bit_o = slot.bit_v;
endmodule

// File: rtl/owrom_chk.sv
module owrom_chk
    import owrom_pkg::*;
#(
    parameter int CODE_W = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rst_i,
    input logic              rd_req_i,
    input logic [CODE_W-1:0] rom_code_i,
    input logic              tx_en_o,
    input logic              tx_bit_o,
    input resp_state_e       state_q,
    input logic [IDX_W-1:0]  idx
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    AST_BUSRST_ABORT: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> (state_q == ST_CMD && idx == '0)); // R8

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (idx == $past(idx) || idx == $past(idx) + ONE || idx == '0)); // R2

    AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !bus_rst_i) |=> (state_q == ST_IDLE && !tx_en_o)); // R6

    AST_CMPL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_S_TRUE && rd_req_i && !bus_rst_i) |=>
        (!$stable(rom_code_i) || (tx_en_o && tx_bit_o != $past(tx_bit_o)))); // R4

    AST_WR_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_S_WR && rd_req_i && !bus_rst_i) |=> (state_q == ST_S_WR && !tx_en_o)); // R11
endmodule

bind owrom_responder owrom_chk #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rst_i (bus_rst_i),
    .rd_req_i  (rd_req_i),
    .rom_code_i(rom_code_i),
    .tx_en_o   (tx_en_o),
    .tx_bit_o  (tx_bit_o),
    .state_q   (state_q),
    .idx       (idx)
);

// File: tb/sim_owrom_responder.sv
module sim_owrom_responder;
    localparam logic [63:0] CODE_A = 64'hA7_1234_5678_9ABC_01;
    localparam logic [63:0] CODE_B = 64'h3C_FEDC_BA98_7650_01;

    // {command, expected tx_en in first read slot}
    localparam int NV = 7;
    localparam logic [8:0] VEC [NV] = '{
        {8'h33, 1'b1}, {8'h0F, 1'b1}, {8'hF0, 1'b1}, {8'h55, 1'b0},
        {8'hCC, 1'b0}, {8'hA5, 1'b0}, {8'hF1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic brst_a = 1'b0, brst_b = 1'b0;
    logic wr_vld = 1'b0, wr_bit = 1'b0, rd_req = 1'b0;
    logic en_a, bit_a, en_b, bit_b;
    logic line;
    int   n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    owrom_responder u0 (.clk(clk), .rst(rst), .bus_rst_i(brst_a), .wr_vld_i(wr_vld),
        .wr_bit_i(wr_bit), .rd_req_i(rd_req), .rom_code_i(CODE_A),
        .tx_en_o(en_a), .tx_bit_o(bit_a));
    owrom_responder u1 (.clk(clk), .rst(rst), .bus_rst_i(brst_b), .wr_vld_i(wr_vld),
        .wr_bit_i(wr_bit), .rd_req_i(rd_req), .rom_code_i(CODE_B),
        .tx_en_o(en_b), .tx_bit_o(bit_b));

    assign line = (en_a ? bit_a : 1'b1) & (en_b ? bit_b : 1'b1);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_reset(input logic both);
        @(negedge clk); brst_a = 1'b1; brst_b = both;
        @(negedge clk); brst_a = 1'b0; brst_b = 1'b0;
    endtask

    task automatic wr_slot(input logic b);
        @(negedge clk); wr_vld = 1'b1; wr_bit = b;
        @(negedge clk); wr_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_slot(v[i]);
    endtask

    // sample the line value at a falling edge, then close the slot
    task automatic rd_slot(output logic v);
        @(negedge clk); v = line; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic v, t, c;
        logic [63:0] got;
        int errs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 silent after rst", {63'd0, en_a}, 64'd0);
        send_byte(8'h33);
        @(negedge clk);
        chk("R10 command ignored without bus reset", {63'd0, en_a}, 64'd0);

        // opcode table
        for (int k = 0; k < NV; k++) begin
            bus_reset(1'b0);
            send_byte(VEC[k][8:1]);
            @(negedge clk);
            chk($sformatf("R2/R4/R7 opcode %h en", VEC[k][8:1]), {63'd0, en_a}, {63'd0, VEC[k][0]});
            if (VEC[k][0]) chk("R2/R4 first bit", {63'd0, bit_a}, {63'd0, CODE_A[0]});
            else begin
                rd_slot(v);
                chk("R7 line stays released", {63'd0, v}, 64'd1);
            end
        end

        // R1: read strobes mid-command ignored, collection silent
        bus_reset(1'b0);
        for (int i = 0; i < 4; i++) wr_slot(OWROM_R1_CMD(i));
        @(negedge clk);
        chk("R1 silent while collecting", {63'd0, en_a}, 64'd0);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        for (int i = 4; i < 8; i++) wr_slot(OWROM_R1_CMD(i));
        @(negedge clk);
        chk("R1 command still decoded", {63'd0, en_a}, 64'd1);

        // R2 / R3 full read, with R11 stray write inside
        got = '0;
        for (int i = 0; i < 64; i++) begin
            if (i == 20) wr_slot(1'b0);
            rd_slot(v); got[i] = v;
        end
        chk("R2 R11 read-ROM stream", got, CODE_A);
        @(negedge clk);
        chk("R3 silent after 64 bits", {63'd0, en_a}, 64'd0);
        rd_slot(v);
        chk("R3 line released", {63'd0, v}, 64'd1);

        // R4 / R5 full search with matching writes; stray read in write phase
        bus_reset(1'b0); send_byte(8'hF0);
        errs = 0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(t); rd_slot(c);
            if (t !== CODE_A[i] || c !== ~CODE_A[i]) errs++;
            if (i == 7) begin rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; end
            wr_slot(CODE_A[i]);
        end
        chk("R4 R11 search true/complement", errs, 0);
        @(negedge clk);
        chk("R5 silent after 64 matched", {63'd0, en_a}, 64'd0);

        // R6 mismatch at bit 5
        bus_reset(1'b0); send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            rd_slot(t); rd_slot(c);
            wr_slot(i == 5 ? ~CODE_A[i] : CODE_A[i]);
        end
        @(negedge clk);
        chk("R6 dropped after mismatch", {63'd0, en_a}, 64'd0);
        wr_slot(CODE_A[6]); rd_slot(v);
        chk("R6 slots ignored after drop", {63'd0, v}, 64'd1);

        // R8 bus reset mid-read
        bus_reset(1'b0); send_byte(8'h0F);
        for (int i = 0; i < 10; i++) rd_slot(v);
        bus_reset(1'b0);
        chk("R8 abort to collection", {63'd0, en_a}, 64'd0);
        send_byte(8'hF0); rd_slot(v);
        chk("R8 new search complement bit0", {62'd0, en_a, bit_a}, {62'd0, 1'b1, ~CODE_A[0]});

        // R9 two responders, master picks 0 on conflict
        bus_reset(1'b1); send_byte(8'hF0);
        got = '0; errs = 0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(t); rd_slot(c);
            if (t && c) errs++;
            got[i] = (t != c) ? t : 1'b0;
            wr_slot(got[i]);
        end
        chk("R9 wired-AND search isolates one code", got, CODE_B);
        chk("R9 no empty-bus bit", errs, 0);
        @(negedge clk);
        chk("R9 both silent at end", {62'd0, en_a, en_b}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic OWROM_R1_CMD(input int i);
        logic [7:0] op = 8'h33;
        return op[i];
    endfunction
endmodule